// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two levels of page tables from memory. The upper ten bits of the address select a word in a page directory, which is one page in size. The directory's physical page number comes from a base input. The entry read there names the physical page of a partial page table. The middle ten bits select a word in that table, and the entry found there supplies the final physical page number. That number is joined with the low twelve bits of the address.

Both table reads go through one read port. The port holds a request until the memory returns a valid strobe, so the memory may take any number of cycles to answer. If either entry has its resident bit clear, the walker stops and reports a fault. The fault report states which level failed, so that software can handle the missing page.

The walker accepts one request at a time. It raises a one-cycle completion or fault pulse, and then it is ready for the next request.

Top module: `pt_walker`

## Requirements
- R1: While reset is held, and on the first cycle after it, `req_ready` is 1 and `mem_req`, `done_valid` and `fault_valid` are 0.
- R2: A request accepted on a rising edge (`req_valid` and `req_ready` both 1) makes `mem_req` go high from that edge on. The first `mem_addr` is `{dir_base_ppn, 12'h000} + dir_index*4`, where `dir_index` is `req_vaddr[31:22]`.
- R3: After a resident directory entry returns, the walker issues a second read at `{entry_ppn, 12'h000} + tbl_index*4`, where `tbl_index` is `req_vaddr[21:12]`. An entry is a 32-bit word laid out as bits [31:2] physical page number, bit 1 dirty, bit 0 resident.
- R4: When the leaf entry is resident, `done_valid` is 1 for exactly one cycle, and `done_paddr` equals `{leaf_ppn, req_vaddr[11:0]}`.
- R5: A directory entry with resident bit 0 gives one `fault_valid` pulse with `fault_level` 0, and no second memory read is issued.
- R6: A leaf entry with resident bit 0 gives one `fault_valid` pulse with `fault_level` 1.
- R7: `req_ready` is 1 only when the walker is idle. A `req_valid` raised while the walker is busy is ignored and produces no result.
- R8: In each read state the walker holds `mem_req` and a stable `mem_addr` until `mem_rvalid` arrives. This holds for any response latency, including a response in the same cycle as the request.
- R9: `done_dirty` reports the dirty bit of the leaf entry. The dirty bit of the directory entry has no effect on it.
- R10: `done_valid` and `fault_valid` are never high together. Each lasts one cycle, and the walker is ready again on the following cycle.
- R11: The address and base are captured when a request is accepted. Changing `req_vaddr` or `dir_base_ppn` during a walk has no effect on its reads or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| dir_base_ppn | input | 30 | Physical page number of the page directory |
| req_ready | output | 1 | Walker is idle and will accept a request |
| mem_req | output | 1 | Table read request, held until answered |
| mem_addr | output | 42 | Byte address of the table entry being read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Table entry returned by memory |
| done_valid | output | 1 | One-cycle pulse: translation finished |
| done_paddr | output | 42 | Translated physical address |
| done_dirty | output | 1 | Dirty bit of the leaf entry |
| fault_valid | output | 1 | One-cycle pulse: non-resident entry found |
| fault_level | output | 1 | 0 = directory entry faulted, 1 = leaf entry faulted |

## Verification
The directory read becomes visible on the port one cycle after the request is accepted. Each read is answered a chosen number of cycles later, from zero to seven. A walk then moves on at the edge that samples `mem_rvalid`, so the table read, or the result pulse, appears in the cycle after the strobe. The bench drives its inputs and samples every output on the falling edge. The memory model checks each read address at the moment it answers. A monitor compares each `done_valid` or `fault_valid` pulse, in the cycle it is present, against the next entry in the expected-result queue. Because of this, no check depends on a fixed cycle count. Any extra read or extra result finds an empty queue and is reported as a failure.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    // Walk progress
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DIR   = 3'd1,
        ST_TBL   = 3'd2,
        ST_DONE  = 3'd3,
        ST_FAULT = 3'd4
    } walk_state_e;

    // Fixed positions of the flag bits inside a table entry
    localparam int unsigned RES_POS   = 0;
    localparam int unsigned DIRTY_POS = 1;
    localparam int unsigned FLAG_W    = 2;

    // Fault level encoding
    localparam logic LVL_DIR  = 1'b0;
    localparam logic LVL_LEAF = 1'b1;

endpackage

// File: rtl/ptw_entry_addr.sv
// Byte address of one entry: table page base plus scaled index.
module ptw_entry_addr #(
    parameter int unsigned PPN_W = 30,
    parameter int unsigned IDX_W = 10,
    parameter int unsigned OFF_W = 12
) (
    input  logic [PPN_W-1:0]       base_ppn,
    input  logic [IDX_W-1:0]       index,
    output logic [PPN_W+OFF_W-1:0] addr
);
    localparam int unsigned PA_W      = PPN_W + OFF_W;
    localparam int unsigned ENTRY_W   = PPN_W + ptw_pkg::FLAG_W;
    localparam int unsigned ENTRY_B   = (ENTRY_W + 7) / 8;
    localparam int unsigned ENT_SH    = $clog2(ENTRY_B);

    logic [PA_W-1:0] page_base;
    logic [PA_W-1:0] byte_off;

    always_comb begin
        page_base = {base_ppn, {OFF_W{1'b0}}};
        byte_off  = {{(PA_W-IDX_W){1'b0}}, index} << ENT_SH;
        addr      = page_base + byte_off;
    end
endmodule

// File: rtl/ptw_entry_dec.sv
// Splits a returned table entry into its fields.
module ptw_entry_dec #(
    parameter int unsigned PPN_W = 30
) (
    input  logic [PPN_W+ptw_pkg::FLAG_W-1:0] entry,
    output logic [PPN_W-1:0]                 ppn,
    output logic                             dirty,
    output logic                             resident
);
    always_comb begin
        ppn      = entry[PPN_W+ptw_pkg::FLAG_W-1:ptw_pkg::FLAG_W];
        dirty    = entry[ptw_pkg::DIRTY_POS];
        resident = entry[ptw_pkg::RES_POS];
    end
endmodule

// File: rtl/ptw_ctrl.sv
// Walk sequencer: two-process FSM holding the captured request and results.
module ptw_ctrl #(
    parameter int unsigned DIR_IDX_W = 10,
    parameter int unsigned TBL_IDX_W = 10,
    parameter int unsigned OFF_W     = 12,
    parameter int unsigned PPN_W     = 30
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic [DIR_IDX_W+TBL_IDX_W+OFF_W-1:0] req_vaddr,
    input  logic [PPN_W-1:0]                  dir_base_ppn,
    output logic                              req_ready,
    input  logic                              mem_rvalid,
    input  logic [PPN_W-1:0]                  ent_ppn,
    input  logic                              ent_dirty,
    input  logic                              ent_res,
    input  logic [PPN_W+OFF_W-1:0]            dir_ent_addr,
    input  logic [PPN_W+OFF_W-1:0]            tbl_ent_addr,
    output logic [PPN_W-1:0]                  cur_base_ppn,
    output logic [DIR_IDX_W-1:0]              cur_dir_idx,
    output logic [PPN_W-1:0]                  cur_tbl_ppn,
    output logic [TBL_IDX_W-1:0]              cur_tbl_idx,
    output logic                              mem_req,
    output logic [PPN_W+OFF_W-1:0]            mem_addr,
    output logic                              done_valid,
    output logic [PPN_W+OFF_W-1:0]            done_paddr,
    output logic                              done_dirty,
    output logic                              fault_valid,
    output logic                              fault_level
);
    import ptw_pkg::*;

    localparam int unsigned VA_W = DIR_IDX_W + TBL_IDX_W + OFF_W;

    typedef struct packed {
        walk_state_e          state;
        logic [PPN_W-1:0]     base_ppn;
        logic [DIR_IDX_W-1:0] dir_idx;
        logic [TBL_IDX_W-1:0] tbl_idx;
        logic [OFF_W-1:0]     offset;
        logic [PPN_W-1:0]     tbl_ppn;
        logic [PPN_W-1:0]     leaf_ppn;
        logic                 leaf_dirty;
        logic                 flt_lvl;
    } walk_regs_t;

    walk_regs_t walk_d, walk_q;

    always_comb begin
        walk_d = walk_q;
        unique case (walk_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    walk_d.base_ppn = dir_base_ppn;
                    walk_d.dir_idx  = req_vaddr[VA_W-1 -: DIR_IDX_W];
                    walk_d.tbl_idx  = req_vaddr[OFF_W +: TBL_IDX_W];
                    walk_d.offset   = req_vaddr[OFF_W-1:0];
                    walk_d.state    = ST_DIR;
                end
            end
            ST_DIR: begin
                if (mem_rvalid) begin
                    if (!ent_res) begin
                        walk_d.flt_lvl = LVL_DIR;
                        walk_d.state   = ST_FAULT;
                    end else begin
                        walk_d.tbl_ppn = ent_ppn;
                        walk_d.state   = ST_TBL;
                    end
                end
            end
            ST_TBL: begin
                if (mem_rvalid) begin
                    if (!ent_res) begin
                        walk_d.flt_lvl = LVL_LEAF;
                        walk_d.state   = ST_FAULT;
                    end else begin
                        walk_d.leaf_ppn   = ent_ppn;
                        walk_d.leaf_dirty = ent_dirty;
                        walk_d.state      = ST_DONE;
                    end
                end
            end
            ST_DONE:  walk_d.state = ST_IDLE;
            ST_FAULT: walk_d.state = ST_IDLE;
            default:  walk_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    always_comb begin
        req_ready    = (walk_q.state == ST_IDLE);
        mem_req      = (walk_q.state == ST_DIR) || (walk_q.state == ST_TBL);
        mem_addr     = (walk_q.state == ST_TBL) ? tbl_ent_addr : dir_ent_addr;
        cur_base_ppn = walk_q.base_ppn;
        cur_dir_idx  = walk_q.dir_idx;
        cur_tbl_ppn  = walk_q.tbl_ppn;
        cur_tbl_idx  = walk_q.tbl_idx;
        done_valid   = (walk_q.state == ST_DONE);
        done_paddr   = {walk_q.leaf_ppn, walk_q.offset};
        done_dirty   = walk_q.leaf_dirty;
        fault_valid  = (walk_q.state == ST_FAULT);
        fault_level  = walk_q.flt_lvl;
    end
endmodule

// File: rtl/pt_walker.sv
// Two-level page table walker top.
module pt_walker #(
    parameter int unsigned DIR_IDX_W = 10,
    parameter int unsigned TBL_IDX_W = 10,
    parameter int unsigned OFF_W     = 12,
    parameter int unsigned PPN_W     = 30,
    localparam int unsigned VA_W     = DIR_IDX_W + TBL_IDX_W + OFF_W,
    localparam int unsigned PA_W     = PPN_W + OFF_W,
    localparam int unsigned ENTRY_W  = PPN_W + ptw_pkg::FLAG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [PPN_W-1:0]   dir_base_ppn,
    output logic               req_ready,
    output logic               mem_req,
    output logic [PA_W-1:0]    mem_addr,
    input  logic               mem_rvalid,
    input  logic [ENTRY_W-1:0] mem_rdata,
    output logic               done_valid,
    output logic [PA_W-1:0]    done_paddr,
    output logic               done_dirty,
    output logic               fault_valid,
    output logic               fault_level
);
    logic [PPN_W-1:0]     ent_ppn;
    logic                 ent_dirty;
    logic                 ent_res;
    logic [PA_W-1:0]      dir_ent_addr;
    logic [PA_W-1:0]      tbl_ent_addr;
    logic [PPN_W-1:0]     cur_base_ppn;
    logic [DIR_IDX_W-1:0] cur_dir_idx;
    logic [PPN_W-1:0]     cur_tbl_ppn;
    logic [TBL_IDX_W-1:0] cur_tbl_idx;

    ptw_entry_dec #(.PPN_W(PPN_W)) dec_i (
        .entry    (mem_rdata),
        .ppn      (ent_ppn),
        .dirty    (ent_dirty),
        .resident (ent_res)
    );

    ptw_entry_addr #(.PPN_W(PPN_W), .IDX_W(DIR_IDX_W), .OFF_W(OFF_W)) dir_addr_i (
        .base_ppn (cur_base_ppn),
        .index    (cur_dir_idx),
        .addr     (dir_ent_addr)
    );

    ptw_entry_addr #(.PPN_W(PPN_W), .IDX_W(TBL_IDX_W), .OFF_W(OFF_W)) tbl_addr_i (
        .base_ppn (cur_tbl_ppn),
        .index    (cur_tbl_idx),
        .addr     (tbl_ent_addr)
    );

    ptw_ctrl #(
        .DIR_IDX_W (DIR_IDX_W),
        .TBL_IDX_W (TBL_IDX_W),
        .OFF_W     (OFF_W),
        .PPN_W     (PPN_W)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_vaddr    (req_vaddr),
        .dir_base_ppn (dir_base_ppn),
        .req_ready    (req_ready),
        .mem_rvalid   (mem_rvalid),
        .ent_ppn      (ent_ppn),
        .ent_dirty    (ent_dirty),
        .ent_res      (ent_res),
        .dir_ent_addr (dir_ent_addr),
        .tbl_ent_addr (tbl_ent_addr),
        .cur_base_ppn (cur_base_ppn),
        .cur_dir_idx  (cur_dir_idx),
        .cur_tbl_ppn  (cur_tbl_ppn),
        .cur_tbl_idx  (cur_tbl_idx),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .done_valid   (done_valid),
        .done_paddr   (done_paddr),
        .done_dirty   (done_dirty),
        .fault_valid  (fault_valid),
        .fault_level  (fault_level)
    );
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
    parameter int unsigned PA_W = 42
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            mem_req,
    input logic [PA_W-1:0] mem_addr,
    input logic            mem_rvalid,
    input logic            done_valid,
    input logic            fault_valid
);
    // R2
    walk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_req && !req_ready));

    // R8
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !done_valid && !fault_valid));

    // R10
    result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_valid && fault_valid));

    // R10
    result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid || fault_valid) |=> (!done_valid && !fault_valid && req_ready));
endmodule

bind pt_walker ptw_checker #(.PA_W(PA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_rvalid  (mem_rvalid),
    .done_valid  (done_valid),
    .fault_valid (fault_valid)
);

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [29:0] dir_base_ppn = '0;
    logic        req_ready;
    logic        mem_req;
    logic [41:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done_valid;
    logic [41:0] done_paddr;
    logic        done_dirty;
    logic        fault_valid;
    logic        fault_level;

    always #5 clk = ~clk;

    pt_walker dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_vaddr    (req_vaddr),
        .dir_base_ppn (dir_base_ppn),
        .req_ready    (req_ready),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .mem_rvalid   (mem_rvalid),
        .mem_rdata    (mem_rdata),
        .done_valid   (done_valid),
        .done_paddr   (done_paddr),
        .done_dirty   (done_dirty),
        .fault_valid  (fault_valid),
        .fault_level  (fault_level)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;
    int lat_g    = 0;

    typedef struct {
        bit          is_fault;
        logic [41:0] paddr;
        logic        dirty;
        logic        level;
        string       tag;
    } exp_res_t;

    typedef struct {
        logic [41:0] addr;
        string       tag;
    } exp_rd_t;

    exp_res_t res_q[$];
    exp_rd_t  rd_q[$];
    logic [31:0] mem_img [logic [41:0]];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkent(input logic [29:0] ppn, input logic d, input logic r);
        return {ppn, d, r};
    endfunction

    function automatic logic [41:0] ent_at(input logic [29:0] ppn, input logic [9:0] idx);
        return {ppn, 12'h000} + {30'd0, idx, 2'b00};
    endfunction

    function automatic logic [31:0] rd_img(input logic [41:0] a);
        if (mem_img.exists(a)) return mem_img[a];
        return 32'h0;
    endfunction

    // Memory model: answers each held read after lat_g falling edges
    initial begin
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (rst_n && mem_req) begin
                repeat (lat_g) @(negedge clk);
                if (rd_q.size() == 0) begin
                    check(1'b0, "R5 unexpected read", {22'd0, mem_addr}, 64'd0);
                end else begin
                    exp_rd_t e;
                    e = rd_q.pop_front();
                    check(mem_addr == e.addr, e.tag, {22'd0, mem_addr}, {22'd0, e.addr});
                end
                mem_rdata  = rd_img(mem_addr);
                mem_rvalid = 1'b1;
            end
        end
    end

    // Monitor: compares result pulses with the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                check(!(done_valid && fault_valid), "R10 both pulses", {62'd0, done_valid, fault_valid}, 64'd0);
                if (done_valid || fault_valid) begin
                    if (res_q.size() == 0) begin
                        check(1'b0, "R7 unexpected result", {63'd0, done_valid}, 64'd0);
                    end else begin
                        exp_res_t e;
                        e = res_q.pop_front();
                        check(fault_valid == e.is_fault, {e.tag, " kind"}, {63'd0, fault_valid}, {63'd0, e.is_fault});
                        if (e.is_fault) begin
                            check(fault_level == e.level, {e.tag, " level"}, {63'd0, fault_level}, {63'd0, e.level});
                        end else begin
                            check(done_paddr == e.paddr, {e.tag, " paddr"}, {22'd0, done_paddr}, {22'd0, e.paddr});
                            check(done_dirty == e.dirty, {e.tag, " dirty R9"}, {63'd0, done_dirty}, {63'd0, e.dirty});
                        end
                    end
                end
            end
        end
    end

    // Driver: computes the expected walk and issues the request
    task automatic walk(input logic [9:0] di, input logic [9:0] ti, input logic [11:0] off,
                        input logic [29:0] base, input int lat, input bit poke, input string tag);
        exp_res_t r;
        exp_rd_t  a;
        logic [31:0] de, te;
        a.addr = ent_at(base, di);
        a.tag  = {tag, " R2 dir addr"};
        rd_q.push_back(a);
        de = rd_img(a.addr);
        r.tag = tag;
        r.paddr = '0;
        r.dirty = 1'b0;
        r.level = 1'b0;
        if (!de[0]) begin
            r.is_fault = 1'b1;
            r.level    = 1'b0;
        end else begin
            a.addr = ent_at(de[31:2], ti);
            a.tag  = {tag, " R3 tbl addr"};
            rd_q.push_back(a);
            te = rd_img(a.addr);
            if (!te[0]) begin
                r.is_fault = 1'b1;
                r.level    = 1'b1;
            end else begin
                r.is_fault = 1'b0;
                r.paddr    = {te[31:2], off};
                r.dirty    = te[1];
            end
        end
        res_q.push_back(r);
        lat_g = lat;
        @(negedge clk);
        check(req_ready == 1'b1, "R7 idle ready", {63'd0, req_ready}, 64'd1);
        req_valid    = 1'b1;
        req_vaddr    = {di, ti, off};
        dir_base_ppn = base;
        @(posedge clk);
        #1;
        req_valid    = 1'b0;
        // R11: disturb captured inputs during the walk
        req_vaddr    = ~{di, ti, off};
        dir_base_ppn = ~base;
        if (poke) begin
            @(negedge clk);
            check(req_ready == 1'b0, "R7 busy not ready", {63'd0, req_ready}, 64'd0);
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (res_q.size() != 0) @(negedge clk);
        @(negedge clk);
        check(req_ready == 1'b1 && mem_req == 1'b0, {tag, " R10 ready after result"},
              {62'd0, req_ready, mem_req}, 64'd2);
        check(rd_q.size() == 0, {tag, " R5 reads consumed"}, 64'(rd_q.size()), 64'd0);
    endtask

    localparam logic [29:0] B0 = 30'h0000010;
    localparam logic [29:0] B1 = 30'h0000050;
    localparam logic [29:0] T0 = 30'h0000020;
    localparam logic [29:0] T1 = 30'h0000030;

    initial begin
        // Directory under B0
        mem_img[ent_at(B0, 10'd1)]   = mkent(T0, 1'b0, 1'b1);
        mem_img[ent_at(B0, 10'd2)]   = mkent(30'h0000077, 1'b0, 1'b0);
        mem_img[ent_at(B0, 10'd3)]   = mkent(T1, 1'b0, 1'b1);
        mem_img[ent_at(B0, 10'h3FF)] = mkent(T0, 1'b1, 1'b1);
        // Directory under B1
        mem_img[ent_at(B1, 10'd0)]   = mkent(T1, 1'b0, 1'b1);
        // Leaf tables
        mem_img[ent_at(T0, 10'd5)]   = mkent(30'h2ABCDE1, 1'b1, 1'b1);
        mem_img[ent_at(T0, 10'd6)]   = mkent(30'h0000099, 1'b1, 1'b0);
        mem_img[ent_at(T0, 10'd7)]   = mkent(30'h0012345, 1'b0, 1'b1);
        mem_img[ent_at(T1, 10'h3FF)] = mkent(30'h3FFFFFF, 1'b1, 1'b1);
        mem_img[ent_at(T1, 10'd0)]   = mkent(30'h0000456, 1'b0, 1'b1);

        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1 ready in reset", {63'd0, req_ready}, 64'd1);
        check(!mem_req && !done_valid && !fault_valid, "R1 quiet in reset",
              {61'd0, mem_req, done_valid, fault_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && !mem_req, "R1 after reset", {62'd0, req_ready, mem_req}, 64'd2);

        walk(10'd1,   10'd5,   12'h123, B0, 0, 1'b0, "R4 zero-latency hit");
        walk(10'd1,   10'd7,   12'hFFF, B0, 3, 1'b0, "R8 latency-3 hit");
        walk(10'd2,   10'd5,   12'h000, B0, 1, 1'b0, "R5 dir fault");
        walk(10'd1,   10'd6,   12'h010, B0, 2, 1'b0, "R6 leaf fault");
        walk(10'd3,   10'h3FF, 12'h000, B0, 5, 1'b1, "R7 R11 top index");
        walk(10'd0,   10'd0,   12'h800, B1, 7, 1'b0, "R11 other base");
        walk(10'h3FF, 10'd7,   12'h0AB, B0, 0, 1'b0, "R9 dir dirty ignored");
        walk(10'd0,   10'd0,   12'h000, B0, 4, 1'b1, "R5 unmapped dir");
        walk(10'h3FF, 10'd5,   12'h456, B0, 6, 1'b0, "R3 back-to-back hit");

        repeat (5) @(negedge clk);
        check(!done_valid && !fault_valid, "R7 no stray result", {62'd0, done_valid, fault_valid}, 64'd0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule